// File: doc/BRIEF.md
# Block Check Character Generator

This block produces an error-detection word for a stream of data words. Words enter one per cycle in which `in_valid` is high. A start marker opens a block and an end marker closes it. Two block modes build a single check word over the whole block. The longitudinal mode folds every word in with XOR. The cyclic mode XORs each word into an accumulator and then rotates the accumulator one bit to the left. When the closing word has been absorbed, the block presents the finished check word so that the sender can append it after the last data word.

A third mode works per word. Each word leaves the block with one extra bit set above its top bit. That bit makes the total count of ones even or odd, as `odd_sel` selects. Both ends of a link must agree on the same parity sense. One flipped bit in a word shows up as a parity error. Two flipped bits in the same word do not.

On the receive side, the block recomputes the check word over the received block. A received check word can then be presented on the compare input. The block raises a mismatch flag when the two differ.

Top module: `bcc_gen`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `chk_valid`, `par_valid` and `mismatch` are 0 and `chk_word` is all zeros.
- R2: With `mode` = 2'b00 (longitudinal), the check word of a block is the XOR of all its accepted words.
- R3: With `mode` = 2'b01 (cyclic), an accumulator starts at zero. For each accepted word it becomes rotate-left-by-one of (accumulator XOR word). The value after the last word is the check word.
- R4: A word accepted with `in_first` high starts from a zero accumulator, whatever earlier words were absorbed. This applies even if the previous block never ended.
- R5: `chk_valid` is high for exactly the one cycle after the clock edge that accepts a word with `in_last` high in a block mode. `chk_word` takes the new value at that edge and keeps it until the next block ends.
- R6: Cycles with `in_valid` low change neither the accumulator nor any output, whatever is on `in_word`, `in_first` or `in_last`.
- R7: When `mode[1]` is 1 (parity), each accepted word appears one cycle later on `par_word`, with the data in bits W-1:0 and the parity bit in bit W, and `par_valid` is high for that cycle. The count of ones in `par_word` is even when `odd_sel` = 0 and odd when `odd_sel` = 1.
- R8: Words accepted in parity mode leave `chk_word` unchanged and never raise `chk_valid`.
- R9: One cycle after `rx_check_valid` is high, `mismatch` shows whether `rx_check` differed from the `chk_word` presented in that cycle. `mismatch` holds its value until the next compare.
- R10: A block of a single word (`in_first` and `in_last` both high) gives that word in longitudinal mode and the word rotated left by one in cyclic mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_word | input | W | Data word |
| in_valid | input | 1 | Word is accepted this cycle |
| in_first | input | 1 | Accepted word opens a block |
| in_last | input | 1 | Accepted word closes a block |
| mode | input | 2 | 00 longitudinal, 01 cyclic, 1x parity |
| odd_sel | input | 1 | Parity sense: 0 even, 1 odd |
| rx_check | input | W | Received check word to compare |
| rx_check_valid | input | 1 | Compare strobe |
| chk_word | output | W | Check word of the last finished block |
| chk_valid | output | 1 | One-cycle pulse when a new check word is ready |
| par_word | output | W+1 | Word with parity bit on top |
| par_valid | output | 1 | `par_word` is new this cycle |
| mismatch | output | 1 | Last compare found a difference |

## Verification
Every result of this block comes from one register stage. The check word and its pulse, the parity word and the mismatch flag each appear one cycle after the edge that accepts the triggering word or compare strobe. The bench changes inputs on falling edges and reads outputs on the next falling edge, which lands inside that one-cycle window. Held values are checked one more cycle later, to show that pulses drop and stored words stay.

// File: rtl/bcc_gen.sv
module bcc_gen #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] in_word,
  input  logic         in_valid,
  input  logic         in_first,
  input  logic         in_last,
  input  logic [1:0]   mode,
  input  logic         odd_sel,
  input  logic [W-1:0] rx_check,
  input  logic         rx_check_valid,
  output logic [W-1:0] chk_word,
  output logic         chk_valid,
  output logic [W:0]   par_word,
  output logic         par_valid,
  output logic         mismatch
);

  logic [W-1:0] acc;
  logic [W-1:0] mixed;
  logic [W-1:0] nxt;
  logic         take;
  logic         par_take;

  assign take     = in_valid & ~mode[1];
  assign par_take = in_valid & mode[1];
  assign mixed    = (in_first ? '0 : acc) ^ in_word;
  assign nxt      = mode[0] ? {mixed[W-2:0], mixed[W-1]} : mixed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc       <= '0;
      chk_word  <= '0;
      chk_valid <= 1'b0;
      par_word  <= '0;
      par_valid <= 1'b0;
      mismatch  <= 1'b0;
    end else begin
      chk_valid <= take & in_last;
      par_valid <= par_take;
      if (take) acc <= nxt;
      if (take && in_last) chk_word <= nxt;
      if (par_take) par_word <= {(^in_word) ^ odd_sel, in_word};
      if (rx_check_valid) mismatch <= (rx_check != chk_word);
    end
  end

endmodule

// File: rtl/bcc_gen_chk.sv
module bcc_gen_chk #(
  parameter int W = 6
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] in_word,
  input logic         in_valid,
  input logic         in_first,
  input logic         in_last,
  input logic [1:0]   mode,
  input logic         odd_sel,
  input logic [W-1:0] rx_check,
  input logic         rx_check_valid,
  input logic [W-1:0] chk_word,
  input logic         chk_valid,
  input logic [W:0]   par_word,
  input logic         par_valid,
  input logic         mismatch
);

  AST_CHK_PULSE_DUE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last && !mode[1]) |=> chk_valid); // R5
  AST_CHK_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |-> $past(in_valid && in_last && !mode[1])); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!chk_valid && !par_valid && $stable(chk_word))); // R6
  AST_PAR_SENSE: assert property (@(posedge clk) disable iff (!rst_n)
    par_valid |-> ((^par_word) == $past(odd_sel))); // R7
  AST_PAR_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    par_valid |-> (par_word[W-1:0] == $past(in_word))); // R7
  AST_PAR_NO_CHK: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode[1]) |=> ($stable(chk_word) && !chk_valid)); // R8
  AST_CMP_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    rx_check_valid |=> (mismatch == ($past(rx_check) != $past(chk_word)))); // R9
  AST_CMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_check_valid |=> $stable(mismatch)); // R9
  AST_SINGLE_LRC: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_first && in_last && mode == 2'b00) |=> (chk_word == $past(in_word))); // R10

endmodule

bind bcc_gen bcc_gen_chk #(.W(W)) i_bcc_gen_chk (.*);

// File: tb/test_bcc_gen.sv
`timescale 1ns/1ps
module test_bcc_gen;
  localparam int W = 6;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] in_word;
  logic         in_valid, in_first, in_last;
  logic [1:0]   mode;
  logic         odd_sel;
  logic [W-1:0] rx_check;
  logic         rx_check_valid;
  logic [W-1:0] chk_word;
  logic         chk_valid;
  logic [W:0]   par_word;
  logic         par_valid;
  logic         mismatch;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bcc_gen #(.W(W)) i_bcc_gen (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] rotl(input logic [W-1:0] v);
    return {v[W-2:0], v[W-1]};
  endfunction

  task automatic put(input logic [W-1:0] w, input bit f, input bit l);
    @(negedge clk);
    in_word = w; in_first = f; in_last = l; in_valid = 1'b1;
  endtask

  task automatic idle(input logic [W-1:0] junk = '0);
    @(negedge clk);
    in_valid = 1'b0; in_word = junk; in_first = junk[0]; in_last = junk[1];
    rx_check_valid = 1'b0;
  endtask

  task automatic run_block(input logic [W-1:0] ws[4], input bit cyc, output logic [W-1:0] exp);
    logic [W-1:0] a = '0;
    mode = {1'b0, cyc};
    for (int i = 0; i < 4; i++) begin
      a = a ^ ws[i];
      if (cyc) a = rotl(a);
      put(ws[i], i == 0, i == 3);
    end
    exp = a;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_word = '0; in_valid = 0; in_first = 0; in_last = 0;
    mode = 2'b00; odd_sel = 0; rx_check = '0; rx_check_valid = 0;
    repeat (3) @(negedge clk);
    check(!chk_valid && !par_valid && !mismatch && chk_word == 0, "R1 in reset", {chk_valid, par_valid, mismatch, chk_word}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!chk_valid && !par_valid && !mismatch && chk_word == 0, "R1 after reset", {chk_valid, par_valid, mismatch, chk_word}, 0);
  endtask

  task automatic t_lrc();
    logic [W-1:0] ws[4] = '{6'h2D, 6'h15, 6'h3A, 6'h07};
    logic [W-1:0] e;
    run_block(ws, 1'b0, e);
    idle();
    check(chk_valid == 1, "R5 pulse lrc", chk_valid, 1);
    check(chk_word == e, "R2 lrc value", chk_word, e);
    idle();
    check(chk_valid == 0, "R5 pulse drops", chk_valid, 0);
    check(chk_word == e, "R5 value held", chk_word, e);
  endtask

  task automatic t_cyc();
    logic [W-1:0] ws[4] = '{6'h2D, 6'h15, 6'h3A, 6'h07};
    logic [W-1:0] e;
    run_block(ws, 1'b1, e);
    idle();
    check(chk_valid == 1 && chk_word == e, "R3 cyclic value", chk_word, e);
    ws = '{6'h3F, 6'h01, 6'h20, 6'h3F};
    run_block(ws, 1'b1, e);
    idle();
    check(chk_word == e, "R3 cyclic second pattern", chk_word, e);
  endtask

  task automatic t_restart();
    mode = 2'b00;
    put(6'h11, 1, 0);
    put(6'h22, 0, 0);
    put(6'h0C, 1, 0);
    put(6'h03, 0, 1);
    idle();
    check(chk_word == (6'h0C ^ 6'h03), "R4 first clears", chk_word, 6'h0C ^ 6'h03);
  endtask

  task automatic t_gaps();
    logic [W-1:0] e = 6'h05 ^ 6'h18 ^ 6'h2A;
    logic [W-1:0] prev;
    mode = 2'b00;
    prev = chk_word;
    put(6'h05, 1, 0);
    idle(6'h3F);
    check(chk_valid == 0 && chk_word == prev, "R6 idle junk ignored", chk_word, prev);
    put(6'h18, 0, 0);
    idle(6'h3E);
    idle(6'h13);
    put(6'h2A, 0, 1);
    idle();
    check(chk_word == e, "R6 gaps keep accumulator", chk_word, e);
  endtask

  task automatic t_single();
    mode = 2'b00;
    put(6'h29, 1, 1);
    idle();
    check(chk_valid && chk_word == 6'h29, "R10 single lrc", chk_word, 6'h29);
    mode = 2'b01;
    put(6'h29, 1, 1);
    idle();
    check(chk_valid && chk_word == rotl(6'h29), "R10 single cyclic", chk_word, rotl(6'h29));
  endtask

  task automatic t_parity();
    logic [W-1:0] ws[4] = '{6'h00, 6'h01, 6'h3F, 6'h2A};
    logic [W-1:0] held = chk_word;
    for (int s = 0; s < 2; s++) begin
      for (int i = 0; i < 4; i++) begin
        logic [W:0] e;
        mode = 2'b10; odd_sel = s[0];
        e = {(^ws[i]) ^ s[0], ws[i]};
        put(ws[i], i == 0, i == 3);
        idle();
        check(par_valid && par_word == e, "R7 parity word", par_word, e);
        check(!chk_valid && chk_word == held, "R8 parity leaves check", chk_word, held);
      end
    end
    mode = 2'b11; odd_sel = 0;
    put(6'h07, 1, 1);
    idle();
    check(par_valid && par_word == {1'b1, 6'h07}, "R7 mode 11 even", par_word, {1'b1, 6'h07});
    idle();
    check(!par_valid, "R7 valid drops", par_valid, 0);
  endtask

  task automatic t_compare();
    logic [W-1:0] c;
    mode = 2'b00;
    put(6'h12, 1, 0);
    put(6'h34, 0, 1);
    idle();
    c = 6'h12 ^ 6'h34;
    @(negedge clk); rx_check = c; rx_check_valid = 1;
    idle();
    check(mismatch == 0, "R9 equal compare", mismatch, 0);
    @(negedge clk); rx_check = c ^ 6'h04; rx_check_valid = 1;
    idle();
    check(mismatch == 1, "R9 unequal compare", mismatch, 1);
    idle(); idle();
    check(mismatch == 1, "R9 flag holds", mismatch, 1);
    @(negedge clk); rx_check = c; rx_check_valid = 1;
    idle();
    check(mismatch == 0, "R9 flag clears on match", mismatch, 0);
  endtask

  initial begin
    t_reset();
    t_lrc();
    t_cyc();
    t_restart();
    t_gaps();
    t_single();
    t_parity();
    t_compare();
    idle();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule